// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer of 64 words, each 36 bits wide, placed between two clock domains that have no fixed phase or frequency relation. The producer side offers a word and raises a write enable. The word is stored on the next write-clock edge unless the buffer is full. The consumer side raises a read enable. On the next read-clock edge the oldest word is loaded into a registered output, unless the buffer is empty.

Each side has two active-low status flags of its own. The write side has full and almost-full. The read side has empty and almost-empty. Each side's flags come from its own pointer and a copy of the other side's pointer. That copy is Gray coded and crosses the boundary through two registers clocked by the receiving side's clock. Because of this, a flag released by activity on the other side changes only on the second edge of its own clock.

One small threshold register sets both almost flags. It is loaded from a dedicated input while reset is held.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst` is high, on the following edges of each clock, both pointers and `dout` clear to zero. `empty_n` and `aempty_n` read 0, and `full_n` and `afull_n` read 1.
- R2: A read-clock edge with `ren` high and `empty_n` high loads the oldest stored word into `dout`. Words come out in the order in which they were accepted. `dout` never changes on an edge where `ren` is low.
- R3: Let N be the count seen by the read side, that is, the synchronized write pointer minus the read pointer. `empty_n` is 0 exactly when N is 0. `aempty_n` is 0 exactly when N is at most X, where X is the loaded threshold. `empty_n` only falls on the edge after an accepted read.
- R4: Let M be the count seen by the write side, that is, the write pointer minus the synchronized read pointer. `full_n` is 0 exactly when M is 64. `afull_n` is 0 exactly when M is at least 64 - X. `full_n` only falls on the edge after an accepted write.
- R5: A read request while `empty_n` is 0 is ignored. `dout` holds its value and the read pointer does not move, so the next word written is the next word read.
- R6: A write request while `full_n` is 0 is ignored. Neither the write pointer nor any stored word changes.
- R7: After a write into an empty buffer, `empty_n` stays 0 through the first rising read-clock edge after the write edge. It turns 1 on the second rising read-clock edge, and the word can be read on the edge after that.
- R8: After a read from a full buffer, `full_n` stays 0 through the first rising write-clock edge after the read edge. It turns 1 on the second rising write-clock edge.
- R9: The threshold X is captured from `ofs_in` on write-clock edges while `rst` is high, and it holds its value otherwise. Legal values are 1 to 31. A new X moves both almost thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high synchronous reset for both domains |
| ofs_in | input | 6 | Almost-flag threshold, captured during reset |
| wclk | input | 1 | Write-side clock |
| wen | input | 1 | Write request |
| din | input | 36 | Word to store |
| full_n | output | 1 | Low when no location is free (write domain) |
| afull_n | output | 1 | Low when at most X locations are free (write domain) |
| rclk | input | 1 | Read-side clock |
| ren | input | 1 | Read request |
| dout | output | 36 | Registered output word |
| empty_n | output | 1 | Low when nothing is readable (read domain) |
| aempty_n | output | 1 | Low when at most X words are readable (read domain) |

## Verification
The case that needs care is an accepted write and an accepted read landing in the same stretch of time. Each side then works from a stale view of the other side's pointer. The bench runs writer and reader processes at once, with two clock periods that never share an edge. Some phases start against a full buffer, so writes wait on reads that are moving the full flag, and others start against an almost-empty buffer. Every word read is compared with a queue model, and after each phase the four flags are compared with the expected table. Directed cases count the exact read-clock and write-clock edges on which empty and full release after the other side acts.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          rst,
  input  logic [AW-1:0] ofs_in,
  input  logic          wclk,
  input  logic          wen,
  input  logic [DW-1:0] din,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          ren,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ofs;
  logic [PW-1:0] wbin, wgray, wnext, rbin, rgray, rnext;
  logic [PW-1:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic [PW-1:0] wcnt, rcnt;
  logic          wr_ok, rd_ok;

  assign wr_ok    = wen && full_n;
  assign rd_ok    = ren && empty_n;
  assign wnext    = wbin + PW'(1);
  assign rnext    = rbin + PW'(1);
  assign wcnt     = wbin - gray2bin(rg_w2);
  assign rcnt     = gray2bin(wg_r2) - rbin;
  assign full_n   = wcnt != PW'(DEPTH);
  assign afull_n  = wcnt < (PW'(DEPTH) - PW'(ofs));
  assign empty_n  = rcnt != '0;
  assign aempty_n = rcnt > PW'(ofs);

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
      ofs   <= ofs_in;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (!rst && wr_ok) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
      dout  <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (rd_ok) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
    end
  end
endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          rst,
  input logic [AW-1:0] ofs_in,
  input logic          wclk,
  input logic          wen,
  input logic [DW-1:0] din,
  input logic          full_n,
  input logic          afull_n,
  input logic          rclk,
  input logic          ren,
  input logic [DW-1:0] dout,
  input logic          empty_n,
  input logic          aempty_n
);
  a_r3_empty_implies_aempty: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |-> !aempty_n);

  a_r3_empty_only_after_read: assert property (@(posedge rclk) disable iff (rst)
    $fell(empty_n) |-> $past(ren));

  a_r4_full_implies_afull: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> !afull_n);

  a_r4_full_only_after_write: assert property (@(posedge wclk) disable iff (rst)
    $fell(full_n) |-> $past(wen));

  a_r2_dout_idle_hold: assert property (@(posedge rclk) disable iff (rst)
    !ren |=> $stable(dout));

  a_r5_empty_read_ignored: assert property (@(posedge rclk) disable iff (rst)
    (ren && !empty_n) |=> $stable(dout));
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.DW(DW), .AW(AW)) chk (.*);

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RHALF      = 7;
  localparam int DW         = 36;
  localparam int AW         = 6;
  localparam int DEPTH      = 64;
  localparam int NPH        = 12;
  localparam int PH_W [NPH] = '{10, 0, 1, 1, 46, 1, 7, 1, 30,  0, 20, 40};
  localparam int PH_R [NPH] = '{ 0, 3, 0, 0,  0, 0, 0, 0, 30, 56, 28, 33};
  localparam int PH_G [NPH] = '{ 3, 2, 1, 1,  5, 1, 4, 1,  3,  4,  2,  6};

  logic          rst = 1'b1;
  logic [AW-1:0] ofs_in = 6'd8;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          full_n, afull_n, empty_n, aempty_n;

  dual_clock_fifo #(.DW(DW), .AW(AW)) uut (
    .rst(rst), .ofs_in(ofs_in), .wclk(wclk), .wen(wen), .din(din),
    .full_n(full_n), .afull_n(afull_n), .rclk(rclk), .ren(ren),
    .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n));

  initial forever #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin #1; forever #RHALF rclk = ~rclk; end

  int tests = 0, fails = 0, xval = 8, seq = 1;
  logic [DW-1:0] q [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_word();
    logic [DW-1:0] v = DW'(seq) ^ (DW'(seq) << 17) ^ DW'(36'hA5000_0000);
    seq++;
    return v;
  endfunction

  task automatic do_reset(input int x);
    rst = 1'b1; ofs_in = AW'(x); xval = x; wen = 1'b0; ren = 1'b0;
    q.delete();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(posedge wclk); rst <= 1'b0;
    #1;
  endtask

  task automatic write_words(input int n, input int gap);
    @(posedge wclk); #1;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] v;
      while (!full_n) begin @(posedge wclk); #1; end
      v = next_word();
      wen = 1'b1; din = v;
      @(posedge wclk); wen <= 1'b0;
      q.push_back(v);
      #1;
      if (i % gap == gap - 1) begin @(posedge wclk); #1; end
    end
  endtask

  task automatic read_words(input int n, input int gap);
    @(posedge rclk); #1;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] e;
      while (!empty_n) begin @(posedge rclk); #1; end
      ren = 1'b1;
      @(posedge rclk); ren <= 1'b0;
      #1;
      e = q.pop_front();
      chk("R2 data order", 64'(dout), 64'(e));
      if (i % gap == gap - 1) begin @(posedge rclk); #1; end
    end
  endtask

  task automatic settle_check();
    int n;
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
    n = q.size();
    chk("R3 empty_n", 64'(empty_n), 64'(n != 0));
    chk("R3 aempty_n", 64'(aempty_n), 64'(n > xval));
    chk("R4 full_n", 64'(full_n), 64'(n != DEPTH));
    chk("R4 afull_n", 64'(afull_n), 64'(n < DEPTH - xval));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(8);
    chk("R1 dout", 64'(dout), 64'd0);
    chk("R1 empty_n", 64'(empty_n), 64'd0);
    chk("R1 aempty_n", 64'(aempty_n), 64'd0);
    chk("R1 full_n", 64'(full_n), 64'd1);
    chk("R1 afull_n", 64'(afull_n), 64'd1);

    // R5: reads against an empty buffer
    @(posedge rclk); ren <= 1'b1;
    repeat (6) @(posedge rclk);
    ren <= 1'b0;
    #1;
    chk("R5 dout held", 64'(dout), 64'd0);
    chk("R5 still empty", 64'(empty_n), 64'd0);

    // R7: empty release on the second read-clock edge
    @(posedge wclk); #1;
    begin
      logic [DW-1:0] v = next_word();
      wen = 1'b1; din = v;
      @(posedge wclk); wen <= 1'b0;
      q.push_back(v);
      @(posedge rclk); #1;
      chk("R7 empty after 1st edge", 64'(empty_n), 64'd0);
      @(posedge rclk); #1;
      chk("R7 ready after 2nd edge", 64'(empty_n), 64'd1);
      ren = 1'b1;
      @(posedge rclk); ren <= 1'b0;
      #1;
      chk("R5 R7 first word read", 64'(dout), 64'(q.pop_front()));
    end
    settle_check();

    for (int p = 0; p < NPH; p++) begin
      fork
        write_words(PH_W[p], PH_G[p]);
        read_words(PH_R[p], PH_G[p] + 1);
      join
      settle_check();
    end

    // R6: writes against a full buffer, then R8 release timing
    write_words(DEPTH - q.size(), 1);
    settle_check();
    @(posedge wclk); wen <= 1'b1; din <= '1;
    repeat (8) @(posedge wclk);
    wen <= 1'b0;
    #1;
    chk("R6 full held", 64'(full_n), 64'd0);
    @(posedge rclk); ren <= 1'b1;
    @(posedge rclk); ren <= 1'b0;
    @(posedge wclk); #1;
    chk("R8 full after 1st edge", 64'(full_n), 64'd0);
    @(posedge wclk); #1;
    chk("R8 free after 2nd edge", 64'(full_n), 64'd1);
    chk("R2 R8 read word", 64'(dout), 64'(q.pop_front()));
    read_words(DEPTH - 1, 5);
    settle_check();

    // R9: new threshold loaded during reset
    do_reset(3);
    write_words(3, 1);  settle_check();
    write_words(1, 1);  settle_check();
    write_words(56, 7); settle_check();
    write_words(1, 1);  settle_check();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule